// File: doc/BRIEF.md
# Exception pending control register

This block is the software-visible register that holds the pending state of three system exceptions: a non-maskable interrupt (NMI), a deferred service-call exception and a periodic timer exception. Software makes an exception pending or removes its pending state by writing 32-bit words. Each exception has its own set bit, and the two maskable exceptions also have their own clear bit. Hardware can raise pending state too. A rising edge on the NMI request line sets the NMI, and a timer event pulse sets the timer exception. The core sends a one-cycle acknowledge when it enters a handler, and that acknowledge clears the matching pending bit. So a read from inside the handler returns 1 only if the exception was raised again after entry.

A read also returns three status fields that the core supplies as inputs: the active vector number, the highest pending vector number and an external-interrupt-pending flag. Arbitration, vector fetch and the timer counter are outside this block. The timer exception is optional and is selected by a parameter.

Top module: `exc_pend_reg`

## Requirements
- R1: While `rst_ni` is low, all three pending bits and `rd_data_o` are 0.
- R2: A write with bit 31 set makes the NMI pending at the next clock edge. A write with bit 31 clear leaves the NMI state unchanged. A read returns the NMI pending state in bit 31.
- R3: A rising edge on `nmi_req_i` makes the NMI pending at the next clock edge. `nmi_ack_i` clears the NMI pending bit. If a set (an edge or a write) arrives in the same cycle as the acknowledge, the NMI stays pending. Holding `nmi_req_i` high does not set it again.
- R4: A write with bit 28 set makes the service-call exception pending, and a read returns its state in bit 28. No input other than a write can set it.
- R5: A write with bit 27 set clears the service-call pending state. If bits 28 and 27 are both set in one write, the state is cleared. `dsc_ack_i` also clears it.
- R6: When the timer is present, bit 26 sets the timer pending state, bit 25 clears it, `tick_evt_i` sets it and `tick_ack_i` clears it. If bits 26 and 25 are both set, the clear wins. A `tick_evt_i` pulse wins over a clear or an acknowledge in the same cycle.
- R7: With `HAS_TIMER=0`, the timer pending state is always 0 and bit 26 always reads 0.
- R8: The read word places fields as follows:
  - `act_vec_i` at bits [VEC_W-1:0], which is bits [8:0] by default.
  - `pend_vec_i` at bits [12+VEC_W-1:12].
  - `ext_pend_i` at bit 22.
  - All other bits, including the write-only bits 27 and 25, read as 0.
- R9: `rd_data_o` is registered. A read strobe in one cycle captures the state and the inputs of that cycle, before any write in the same cycle takes effect. The captured word appears after the next clock edge and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 32 | Write data |
| rd_en_i | input | 1 | Read strobe |
| rd_data_o | output | 32 | Registered read data |
| nmi_req_i | input | 1 | NMI request level; a rising edge sets the NMI pending bit |
| tick_evt_i | input | 1 | Timer event pulse |
| nmi_ack_i | input | 1 | NMI handler entry acknowledge |
| dsc_ack_i | input | 1 | Service-call handler entry acknowledge |
| tick_ack_i | input | 1 | Timer handler entry acknowledge |
| act_vec_i | input | VEC_W | Active vector number |
| pend_vec_i | input | VEC_W | Highest pending vector number |
| ext_pend_i | input | 1 | External interrupt pending flag |
| nmi_pend_o | output | 1 | NMI pending |
| dsc_pend_o | output | 1 | Service-call pending |
| tick_pend_o | output | 1 | Timer pending |

## Verification
The bench builds two instances that share the same stimulus. One has `HAS_TIMER=1` and `VEC_W=9`, and the other has `HAS_TIMER=0`. The first instance covers the contention cases between events, clears and acknowledges on the timer bit. The second shows that the absent timer never becomes pending and always reads 0 while the other two exceptions behave identically. Random write words reach set/clear pairs and edge-plus-acknowledge collisions that the directed cases only sample.

// File: rtl/exc_pend_pkg.sv
package exc_pend_pkg;
  localparam int unsigned WORD_W       = 32;
  localparam int unsigned NMI_SET_BIT  = 31;
  localparam int unsigned DSC_SET_BIT  = 28;
  localparam int unsigned DSC_CLR_BIT  = 27;
  localparam int unsigned TICK_SET_BIT = 26;
  localparam int unsigned TICK_CLR_BIT = 25;
  localparam int unsigned EXT_BIT      = 22;
  localparam int unsigned PEND_VEC_LSB = 12;
  localparam int unsigned ACT_VEC_LSB  = 0;

  typedef struct packed {
    logic nmi;
    logic dsc;
    logic tick;
  } pend_state_t;
endpackage

// File: rtl/exc_edge_det.sv
module exc_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic rise_o
);
  logic lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= 1'b0;
    else         lvl_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~lvl_q;
endmodule

// File: rtl/exc_pend_bit.sv
module exc_pend_bit #(
  parameter bit PRESENT = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sw_set_i,
  input  logic sw_clr_i,
  input  logic hw_set_i,
  input  logic ack_i,
  output logic pend_o
);
  localparam logic EN = PRESENT;
  logic pend_q, pend_d;

  // hw set beats everything; sw clear beats sw set; any set beats ack
  always_comb begin
    pend_d = hw_set_i | (sw_set_i & ~sw_clr_i) | (pend_q & ~sw_clr_i & ~ack_i);
    pend_d = pend_d & EN;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= 1'b0;
    else         pend_q <= pend_d;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/exc_rd_port.sv
module exc_rd_port
  import exc_pend_pkg::*;
#(
  parameter int unsigned VEC_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_en_i,
  input  pend_state_t       state_i,
  input  logic              ext_pend_i,
  input  logic [VEC_W-1:0]  pend_vec_i,
  input  logic [VEC_W-1:0]  act_vec_i,
  output logic [WORD_W-1:0] rd_data_o
);
  logic [WORD_W-1:0] word_c, rd_q;

  always_comb begin
    word_c = '0;
    word_c[NMI_SET_BIT]                  = state_i.nmi;
    word_c[DSC_SET_BIT]                  = state_i.dsc;
    word_c[TICK_SET_BIT]                 = state_i.tick;
    word_c[EXT_BIT]                      = ext_pend_i;
    word_c[PEND_VEC_LSB +: VEC_W]        = pend_vec_i;
    word_c[ACT_VEC_LSB +: VEC_W]         = act_vec_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rd_q <= '0;
    else if (rd_en_i) rd_q <= word_c;
  end

  assign rd_data_o = rd_q;
endmodule

// File: rtl/exc_pend_reg.sv
module exc_pend_reg
  import exc_pend_pkg::*;
#(
  parameter bit          HAS_TIMER = 1'b1,
  parameter int unsigned VEC_W     = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [31:0]       wr_data_i,
  input  logic              rd_en_i,
  output logic [31:0]       rd_data_o,
  input  logic              nmi_req_i,
  input  logic              tick_evt_i,
  input  logic              nmi_ack_i,
  input  logic              dsc_ack_i,
  input  logic              tick_ack_i,
  input  logic [VEC_W-1:0]  act_vec_i,
  input  logic [VEC_W-1:0]  pend_vec_i,
  input  logic              ext_pend_i,
  output logic              nmi_pend_o,
  output logic              dsc_pend_o,
  output logic              tick_pend_o
);
  pend_state_t state;
  logic nmi_rise;
  logic nmi_set_w, dsc_set_w, dsc_clr_w, tick_set_w, tick_clr_w;
  logic unused_wdata;

  assign nmi_set_w  = wr_en_i & wr_data_i[NMI_SET_BIT];
  assign dsc_set_w  = wr_en_i & wr_data_i[DSC_SET_BIT];
  assign dsc_clr_w  = wr_en_i & wr_data_i[DSC_CLR_BIT];
  assign tick_set_w = wr_en_i & wr_data_i[TICK_SET_BIT];
  assign tick_clr_w = wr_en_i & wr_data_i[TICK_CLR_BIT];
  assign unused_wdata = ^{wr_data_i[30:29], wr_data_i[24:0]};

  exc_edge_det u_nmi_edge (
    .clk_i (clk_i), .rst_ni(rst_ni), .lvl_i(nmi_req_i), .rise_o(nmi_rise)
  );

  exc_pend_bit #(.PRESENT(1'b1)) u_nmi (
    .clk_i(clk_i), .rst_ni(rst_ni), .sw_set_i(nmi_set_w), .sw_clr_i(1'b0),
    .hw_set_i(nmi_rise), .ack_i(nmi_ack_i), .pend_o(state.nmi)
  );

  exc_pend_bit #(.PRESENT(1'b1)) u_dsc (
    .clk_i(clk_i), .rst_ni(rst_ni), .sw_set_i(dsc_set_w), .sw_clr_i(dsc_clr_w),
    .hw_set_i(1'b0), .ack_i(dsc_ack_i), .pend_o(state.dsc)
  );

  exc_pend_bit #(.PRESENT(HAS_TIMER)) u_tick (
    .clk_i(clk_i), .rst_ni(rst_ni), .sw_set_i(tick_set_w), .sw_clr_i(tick_clr_w),
    .hw_set_i(tick_evt_i), .ack_i(tick_ack_i), .pend_o(state.tick)
  );

  exc_rd_port #(.VEC_W(VEC_W)) u_rd (
    .clk_i(clk_i), .rst_ni(rst_ni), .rd_en_i(rd_en_i), .state_i(state),
    .ext_pend_i(ext_pend_i), .pend_vec_i(pend_vec_i), .act_vec_i(act_vec_i),
    .rd_data_o(rd_data_o)
  );

  assign nmi_pend_o  = state.nmi;
  assign dsc_pend_o  = state.dsc;
  assign tick_pend_o = state.tick;
endmodule

// File: rtl/exc_pend_chk.sv
module exc_pend_chk #(
  parameter bit HAS_TIMER = 1'b1
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        wr_en_i,
  input logic        w_nmi_set_i,
  input logic        w_dsc_set_i,
  input logic        w_dsc_clr_i,
  input logic        rd_en_i,
  input logic [31:0] rd_data_o,
  input logic        nmi_req_i,
  input logic        tick_evt_i,
  input logic        nmi_ack_i,
  input logic        nmi_pend_o,
  input logic        dsc_pend_o,
  input logic        tick_pend_o
);
  // R2
  nmi_wr_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && w_nmi_set_i) |=> nmi_pend_o);
  // R3
  nmi_ack_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nmi_ack_i && !nmi_req_i && !(wr_en_i && w_nmi_set_i)) |=> !nmi_pend_o);
  // R4
  dsc_sw_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dsc_pend_o) |-> $past(wr_en_i && w_dsc_set_i));
  // R5
  dsc_clr_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && w_dsc_set_i && w_dsc_clr_i) |=> !dsc_pend_o);
  // R6
  tick_evt_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (HAS_TIMER && tick_evt_i) |=> tick_pend_o);
  // R7
  no_timer_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !HAS_TIMER |-> (!tick_pend_o && !rd_data_o[26]));
  // R8
  zero_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_o[30:29] == 2'b00) && !rd_data_o[27] && !rd_data_o[25]);
  // R9
  rd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rd_data_o));
  // R9
  rd_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |=> (rd_data_o[28] == $past(dsc_pend_o)));
endmodule

bind exc_pend_reg exc_pend_chk #(.HAS_TIMER(HAS_TIMER)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i),
  .w_nmi_set_i(wr_data_i[31]), .w_dsc_set_i(wr_data_i[28]), .w_dsc_clr_i(wr_data_i[27]),
  .rd_en_i(rd_en_i), .rd_data_o(rd_data_o), .nmi_req_i(nmi_req_i),
  .tick_evt_i(tick_evt_i), .nmi_ack_i(nmi_ack_i), .nmi_pend_o(nmi_pend_o),
  .dsc_pend_o(dsc_pend_o), .tick_pend_o(tick_pend_o)
);

// File: tb/exc_pend_reg_bench.sv
module exc_pend_reg_bench;
  localparam int CLK_P = 10;
  localparam int VW    = 9;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 0, rd_en = 0, nmi_req = 0, tick_evt = 0;
  logic nmi_ack = 0, dsc_ack = 0, tick_ack = 0, ext_pend = 0;
  logic [31:0] wd = '0;
  logic [VW-1:0] act_vec = '0, pend_vec = '0;
  logic [31:0] rd_a, rd_b;
  logic np_a, dp_a, tp_a, np_b, dp_b, tp_b;

  int checks = 0, failures = 0;
  bit done = 0;
  logic m_nmi = 0, m_dsc = 0, m_tick = 0, m_prev = 0;
  logic [31:0] e_rd = '0, e_rd_nt = '0;

  always #(CLK_P/2) clk = ~clk;

  exc_pend_reg #(.HAS_TIMER(1'b1), .VEC_W(VW)) u_exc_pend_reg (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wd), .rd_en_i(rd_en),
    .rd_data_o(rd_a), .nmi_req_i(nmi_req), .tick_evt_i(tick_evt), .nmi_ack_i(nmi_ack),
    .dsc_ack_i(dsc_ack), .tick_ack_i(tick_ack), .act_vec_i(act_vec), .pend_vec_i(pend_vec),
    .ext_pend_i(ext_pend), .nmi_pend_o(np_a), .dsc_pend_o(dp_a), .tick_pend_o(tp_a));

  exc_pend_reg #(.HAS_TIMER(1'b0), .VEC_W(VW)) u_exc_pend_reg_nt (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wd), .rd_en_i(rd_en),
    .rd_data_o(rd_b), .nmi_req_i(nmi_req), .tick_evt_i(tick_evt), .nmi_ack_i(nmi_ack),
    .dsc_ack_i(dsc_ack), .tick_ack_i(tick_ack), .act_vec_i(act_vec), .pend_vec_i(pend_vec),
    .ext_pend_i(ext_pend), .nmi_pend_o(np_b), .dsc_pend_o(dp_b), .tick_pend_o(tp_b));

  function automatic logic [31:0] word(logic n, logic d, logic t, logic x,
                                       logic [VW-1:0] pv, logic [VW-1:0] av);
    logic [31:0] w = '0;
    w[31] = n; w[28] = d; w[26] = t; w[22] = x;
    w[12 +: VW] = pv; w[VW-1:0] = av;
    return w;
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  task automatic idle();
    wr_en = 0; wd = '0; rd_en = 0; tick_evt = 0;
    nmi_ack = 0; dsc_ack = 0; tick_ack = 0;
  endtask

  // apply current inputs for one cycle, then compare at the next falling edge
  task automatic cyc(string tag);
    logic edge_n, n_nmi, n_dsc, n_tick;
    edge_n = nmi_req & ~m_prev;
    n_nmi  = edge_n | (wr_en & wd[31]) | (m_nmi & ~nmi_ack);
    n_dsc  = (wr_en & wd[28] & ~wd[27]) | (m_dsc & ~(wr_en & wd[27]) & ~dsc_ack);
    n_tick = tick_evt | (wr_en & wd[26] & ~wd[25]) |
             (m_tick & ~(wr_en & wd[25]) & ~tick_ack);
    if (rd_en) begin
      e_rd    = word(m_nmi, m_dsc, m_tick, ext_pend, pend_vec, act_vec);
      e_rd_nt = word(m_nmi, m_dsc, 1'b0, ext_pend, pend_vec, act_vec);
    end
    m_prev = nmi_req; m_nmi = n_nmi; m_dsc = n_dsc; m_tick = n_tick;
    @(negedge clk);
    chk({tag, "/R3"}, "nmi_pend", {31'b0, np_a}, {31'b0, m_nmi});
    chk({tag, "/R5"}, "dsc_pend", {31'b0, dp_a}, {31'b0, m_dsc});
    chk({tag, "/R6"}, "tick_pend", {31'b0, tp_a}, {31'b0, m_tick});
    chk({tag, "/R8"}, "rd_data", rd_a, e_rd);
    chk({tag, "/R7"}, "nt_tick_pend", {31'b0, tp_b}, 32'd0);
    chk({tag, "/R7"}, "nt_rd_data", rd_b, e_rd_nt);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk("R1", "rst_nmi",  {31'b0, np_a}, 32'd0);
    chk("R1", "rst_tick", {31'b0, tp_a}, 32'd0);
    chk("R1", "rst_rd",   rd_a, 32'd0);
    rst_n = 1'b1;

    // R2: write of zeros has no effect, then set via bit 31, then read back
    idle(); wr_en = 1; wd = 32'h0000_0000; cyc("R2");
    chk("R2", "nmi_zero_write", {31'b0, np_a}, 32'd0);
    idle(); wr_en = 1; wd = 32'h8000_0000; cyc("R2");
    chk("R2", "nmi_set", {31'b0, np_a}, 32'd1);
    idle(); rd_en = 1; cyc("R2");
    chk("R2", "nmi_read_bit31", {31'b0, rd_a[31]}, 32'd1);
    // R3: ack clears; held request does not re-set; edge with ack sets
    idle(); nmi_ack = 1; cyc("R3");
    chk("R3", "nmi_ack_clear", {31'b0, np_a}, 32'd0);
    idle(); nmi_req = 1; cyc("R3");
    chk("R3", "nmi_edge_set", {31'b0, np_a}, 32'd1);
    idle(); nmi_ack = 1; cyc("R3");
    chk("R3", "nmi_held_no_reset", {31'b0, np_a}, 32'd0);
    idle(); nmi_req = 0; cyc("R3");
    idle(); nmi_req = 1; nmi_ack = 1; cyc("R3");
    chk("R3", "nmi_edge_beats_ack", {31'b0, np_a}, 32'd1);
    idle(); nmi_req = 0; nmi_ack = 1; cyc("R3");
    // R4: set service call by write
    idle(); wr_en = 1; wd = 32'h1000_0000; cyc("R4");
    chk("R4", "dsc_set", {31'b0, dp_a}, 32'd1);
    // R5: set+clear in one write clears; ack clears
    idle(); wr_en = 1; wd = 32'h1800_0000; cyc("R5");
    chk("R5", "dsc_clear_wins", {31'b0, dp_a}, 32'd0);
    idle(); wr_en = 1; wd = 32'h1000_0000; cyc("R5");
    idle(); dsc_ack = 1; cyc("R5");
    chk("R5", "dsc_ack_clear", {31'b0, dp_a}, 32'd0);
    // R6: event beats clear and ack; set+clear clears
    idle(); tick_evt = 1; tick_ack = 1; wr_en = 1; wd = 32'h0200_0000; cyc("R6");
    chk("R6", "tick_evt_wins", {31'b0, tp_a}, 32'd1);
    idle(); wr_en = 1; wd = 32'h0600_0000; cyc("R6");
    chk("R6", "tick_clear_wins", {31'b0, tp_a}, 32'd0);
    idle(); wr_en = 1; wd = 32'h0400_0000; cyc("R6");
    // R7: absent timer reads zero
    idle(); rd_en = 1; cyc("R7");
    chk("R7", "nt_bit26", {31'b0, rd_b[26]}, 32'd0);
    chk("R6", "tick_bit26", {31'b0, rd_a[26]}, 32'd1);
    // R8: field placement
    idle(); rd_en = 1; ext_pend = 1; act_vec = 9'h1A5; pend_vec = 9'h0C3; cyc("R8");
    chk("R8", "fields", rd_a & 32'h005F_F1FF, word(0, 0, 0, 1, 9'h0C3, 9'h1A5));
    // R9: read captures pre-write state and holds while idle
    idle(); rd_en = 1; wr_en = 1; wd = 32'h1000_0000; cyc("R9");
    chk("R9", "pre_write_capture", {31'b0, rd_a[28]}, 32'd0);
    idle(); ext_pend = 0; act_vec = 9'h011; cyc("R9");
    chk("R9", "hold", {31'b0, rd_a[28]}, 32'd0);

    for (int i = 0; i < 3000; i++) begin
      idle();
      wr_en    = ($urandom % 10) < 3;
      wd       = $urandom;
      rd_en    = $urandom % 2;
      nmi_req  = $urandom % 2;
      tick_evt = ($urandom % 10) == 0;
      nmi_ack  = ($urandom % 7) == 0;
      dsc_ack  = ($urandom % 7) == 0;
      tick_ack = ($urandom % 7) == 0;
      ext_pend = $urandom % 2;
      act_vec  = VW'($urandom);
      pend_vec = VW'($urandom);
      cyc("RND");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule